// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every condition that may restart a small processor core and turns them into one synchronous core reset, a code naming the cause, and the start address the core fetches from once reset ends. There are four sources: an asynchronous active-low reset pin, a power-on detect level, a one-cycle watchdog expiry pulse and a "clock stalled" level. The clock-stalled level stands in for an analog clock-failure detector and only counts while the clock-monitor enable is high.

Power-on is the only source that gets extra hold time. Once power-on detect goes away, or the block's own asynchronous reset is released, the core stays in reset for a fixed number of settle cycles so the oscillator can stabilise. Restart never saves core state, so the block has no return path. It only chooses where execution begins. Power-on and pin restarts share the highest vector. The clock-failure and watchdog restarts each have their own vector below it.

Top module: `rst_sequencer`

## Requirements
- R1: While rst_ni is low, core_rst_o is 1, cause_o is 0 (power-on) and vec_addr_o is FFFE.
- R2: After rst_ni rises, or after the last rising edge that samples por_i high, core_rst_o stays 1 through the next SETTLE_CYCLES+1 rising edges and drops on edge SETTLE_CYCLES+2 (default 4064 settle cycles).
- R3: pin_rst_ni passes through two synchronizer flops. A falling pin raises core_rst_o on the third rising edge and sets cause_o to 1 (pin).
- R4: When several sources are active together, cause_o takes the highest one in the order power-on (0), pin (1), clock failure (2), watchdog (3).
- R5: vec_addr_o is FFFE for cause 0 or 1, FFFC for cause 2 and FFFA for cause 3.
- R6: clk_stall_i resets the core with cause 2 only while clkmon_en_i is 1. Otherwise it has no effect on any output.
- R7: A single-cycle wdog_timeout_i pulse makes core_rst_o 1 for exactly two cycles, beginning at the edge that samples the pulse, and sets cause_o to 3.
- R8: core_rst_o stays 1 for one cycle after the last cycle in which any request is active.
- R9: cause_o and vec_addr_o keep their values in every cycle with no active request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is treated as a power-on |
| pin_rst_ni | input | 1 | Raw external reset pin, active low, asynchronous |
| por_i | input | 1 | Power-on detect level, active high |
| wdog_timeout_i | input | 1 | Watchdog expiry pulse |
| clk_stall_i | input | 1 | Clock-failure indication from the analog detector |
| clkmon_en_i | input | 1 | Enables reset on clock failure |
| core_rst_o | output | 1 | Synchronous reset to the core, active high |
| vec_addr_o | output | ADDR_W | Reset vector address for the latched cause |
| cause_o | output | 2 | Latched cause: 0 power-on, 1 pin, 2 clock failure, 3 watchdog |

## Verification
Each source is first driven alone, so that a swapped vector or cause code shows up on its own. Sources are then driven in overlapping sets that differ only in the highest member present, which exposes any mistake in the priority order. A clock stall with the monitor disabled is placed directly after a watchdog reset, so a missing enable gate becomes visible as a changed cause. Directed cases measure edge-exact latency: the settle count after power-on, the synchronizer delay on the pin, the two-cycle pulse from a one-cycle watchdog strobe, and the one-cycle release tail.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR  = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_CLK  = 2'd2,
    CAUSE_WDOG = 2'd3
  } rst_cause_e;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;
  logic [1:0]        warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign q_o = sync_q[STAGES-1];

  // R3: output follows the pin two edges later
  p_sync_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && STAGES == 2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/rst_settle_timer.sv
module rst_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 4064,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD;
    else if (por_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (cnt_q == LOAD));
  p_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
  import rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_req_i,
  input  logic       pin_req_i,
  input  logic       clk_stall_i,
  input  logic       clkmon_en_i,
  input  logic       wdog_req_i,
  output logic       hit_o,
  output rst_cause_e cause_o
);
  logic clk_req;
  assign clk_req = clk_stall_i & clkmon_en_i;

  always_comb begin
    hit_o   = 1'b1;
    cause_o = CAUSE_POR;
    if      (por_req_i)  cause_o = CAUSE_POR;
    else if (pin_req_i)  cause_o = CAUSE_PIN;
    else if (clk_req)    cause_o = CAUSE_CLK;
    else if (wdog_req_i) cause_o = CAUSE_WDOG;
    else                 hit_o   = 1'b0;
  end

  // R6: a stalled clock never wins while the monitor is off
  p_clk_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clkmon_en_i |-> !(hit_o && cause_o == CAUSE_CLK));
  // R4: power-on outranks everything
  p_por_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |-> (hit_o && cause_o == CAUSE_POR));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 4064,
  parameter int unsigned ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] VEC_BOOT = 16'hFFFE,
  parameter logic [ADDR_W-1:0] VEC_CLK  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_WDOG = 16'hFFFA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_rst_ni,
  input  logic              por_i,
  input  logic              wdog_timeout_i,
  input  logic              clk_stall_i,
  input  logic              clkmon_en_i,
  output logic              core_rst_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        cause_o
);
  logic       pin_sync;
  logic       settle_busy;
  logic       req_any;
  rst_cause_e cause_nxt;
  rst_cause_e cause_q;
  logic       req_d_q;
  logic       core_rst_q;

  rst_pin_sync #(.STAGES(2)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_rst_ni),
    .q_o    (pin_sync)
  );

  rst_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .por_i  (por_i),
    .busy_o (settle_busy)
  );

  rst_cause_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_req_i   (por_i | settle_busy),
    .pin_req_i   (~pin_sync),
    .clk_stall_i (clk_stall_i),
    .clkmon_en_i (clkmon_en_i),
    .wdog_req_i  (wdog_timeout_i),
    .hit_o       (req_any),
    .cause_o     (cause_nxt)
  );

  // one-cycle tail after the last request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d_q    <= 1'b1;
      core_rst_q <= 1'b1;
      cause_q    <= CAUSE_POR;
    end else begin
      req_d_q    <= req_any;
      core_rst_q <= req_any | req_d_q;
      if (req_any) cause_q <= cause_nxt;
    end
  end

  always_comb begin
    unique case (cause_q)
      CAUSE_CLK:  vec_addr_o = VEC_CLK;
      CAUSE_WDOG: vec_addr_o = VEC_WDOG;
      default:    vec_addr_o = VEC_BOOT;
    endcase
  end

  assign core_rst_o = core_rst_q;
  assign cause_o    = cause_q;

  p_tail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> !$past(req_any));
  p_wdog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_timeout_i |=> core_rst_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_any |=> $stable(cause_o));
  p_por_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (cause_o == CAUSE_POR && core_rst_o));
endmodule

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
  localparam int unsigned SETTLE = 4064;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_rst_ni = 1'b1;
  logic        por_i = 1'b0;
  logic        wdog_timeout_i = 1'b0;
  logic        clk_stall_i = 1'b0;
  logic        clkmon_en_i = 1'b0;
  logic        core_rst_o;
  logic [15:0] vec_addr_o;
  logic [1:0]  cause_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  rst_sequencer #(.SETTLE_CYCLES(SETTLE)) u_rst_sequencer (
    .clk_i, .rst_ni, .pin_rst_ni, .por_i, .wdog_timeout_i,
    .clk_stall_i, .clkmon_en_i, .core_rst_o, .vec_addr_o, .cause_o
  );

  typedef struct packed {
    logic        pin_n;
    logic        wdog;
    logic        stall;
    logic        en;
    logic        exp_rst;
    logic [1:0]  exp_cause;
    logic [15:0] exp_vec;
  } vec_t;

  // levels held four edges; ignored-stall row expects the previous cause
  localparam vec_t TBL [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFE},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 16'hFFFA},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 16'hFFFA},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 16'hFFFC},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 16'hFFFE},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 16'hFFFC},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFE},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 16'hFFFA}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    edges(3);
    check("R1 rst", 32'(core_rst_o), 32'd1);
    check("R1 cause", 32'(cause_o), 32'd0);
    check("R1 vec", 32'(vec_addr_o), 32'hFFFE);

    // R2: settle after release
    rst_ni = 1'b1;
    edges(SETTLE + 1);
    check("R2 held", 32'(core_rst_o), 32'd1);
    edges(1);
    check("R2 released", 32'(core_rst_o), 32'd0);
    check("R2 cause", 32'(cause_o), 32'd0);

    // table walk: R4 R5 R6 R9
    for (int i = 0; i < 8; i++) begin
      pin_rst_ni     = TBL[i].pin_n;
      wdog_timeout_i = TBL[i].wdog;
      clk_stall_i    = TBL[i].stall;
      clkmon_en_i    = TBL[i].en;
      edges(4);
      check("R4/R6 rst", 32'(core_rst_o), 32'(TBL[i].exp_rst));
      check("R4 cause", 32'(cause_o), 32'(TBL[i].exp_cause));
      check("R5 vec", 32'(vec_addr_o), 32'(TBL[i].exp_vec));
      pin_rst_ni = 1'b1; wdog_timeout_i = 1'b0; clk_stall_i = 1'b0; clkmon_en_i = 1'b0;
      edges(4);
      check("R8 idle", 32'(core_rst_o), 32'd0);
      check("R9 hold", 32'(cause_o), 32'(TBL[i].exp_cause));
    end

    // R7: one-cycle watchdog pulse -> two reset cycles
    wdog_timeout_i = 1'b1;
    edges(1);
    wdog_timeout_i = 1'b0;
    check("R7 first", 32'(core_rst_o), 32'd1);
    edges(1);
    check("R7 second", 32'(core_rst_o), 32'd1);
    edges(1);
    check("R7 end", 32'(core_rst_o), 32'd0);
    check("R7 cause", 32'(cause_o), 32'd3);

    // R3: synchronizer latency, R8 tail on release
    pin_rst_ni = 1'b0;
    edges(2);
    check("R3 not yet", 32'(core_rst_o), 32'd0);
    edges(1);
    check("R3 asserted", 32'(core_rst_o), 32'd1);
    check("R3 cause", 32'(cause_o), 32'd1);
    pin_rst_ni = 1'b1;
    edges(3);
    check("R8 tail", 32'(core_rst_o), 32'd1);
    edges(1);
    check("R8 release", 32'(core_rst_o), 32'd0);

    // R4 power-on beats pin; R2 settle from por_i falling
    por_i = 1'b1;
    pin_rst_ni = 1'b0;
    edges(4);
    check("R4 por wins", 32'(cause_o), 32'd0);
    check("R5 por vec", 32'(vec_addr_o), 32'hFFFE);
    pin_rst_ni = 1'b1;
    edges(1);
    por_i = 1'b0;
    edges(SETTLE + 1);
    check("R2 por held", 32'(core_rst_o), 32'd1);
    edges(1);
    check("R2 por released", 32'(core_rst_o), 32'd0);
    check("R9 por cause", 32'(cause_o), 32'd0);

    // R1 again mid-run
    clk_stall_i = 1'b1; clkmon_en_i = 1'b1;
    edges(2);
    check("R6 enabled", 32'(cause_o), 32'd2);
    clk_stall_i = 1'b0; clkmon_en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R1 async rst", 32'(core_rst_o), 32'd1);
    check("R1 async cause", 32'(cause_o), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule